// File: doc/BRIEF.md
# Long-Press Manual Reset Detector

This block turns a long, deliberate press on one or two front-panel buttons into a single reset pulse of fixed length. Short presses are ignored, so the same button can serve ordinary user functions and still reset the system when held for several seconds. In dual mode both buttons must be held together, which makes an accidental reset even less likely.

Each raw active-low button level first passes through a two-flop synchroniser. It then goes through a release filter, which treats a button as let go only after it has stayed high for a number of timebase ticks. A small state machine counts setup ticks while the selected hold condition is true. It then drives the reset pulse for a fixed number of ticks and waits for a release before it can arm again. All timing is counted on a one-cycle `tick` enable, nominally 1 ms. The defaults are 6720 setup ticks and 210 pulse ticks. Shorter counts are set by parameter for simulation.

Top module: `lrd_top`

## Requirements
- R1: While `rst` is high, and after it falls with both buttons released, `rst_out_n` is 1 and `rst_req` is 0.
- R2: A pulse starts only after the hold condition has been true for SETUP_TICKS consecutive ticks. A hold that ends sooner produces no pulse, and the next hold counts from zero.
- R3: With `dual_mode` = 1, the hold condition is both buttons pressed at once. Holding only one produces nothing, and releasing either button during setup restarts the count.
- R4: With `dual_mode` = 0, only `btn_a_n` is watched, and pressing `btn_b_n` alone has no effect on the outputs.
- R5: A pulse drives `rst_out_n` low for exactly PULSE_TICKS ticks. `rst_req` is high for exactly one cycle, the first cycle in which `rst_out_n` is low.
- R6: Only one pulse is issued per hold. After a pulse, no other pulse can occur until the hold condition has been released and then held again for a full setup period.
- R7: A button counts as released only after its synchronised level has stayed high for REL_TICKS consecutive ticks. A shorter high excursion neither restarts a setup count nor re-arms the detector after a pulse.
- R8: While the pulse is active, button activity has no effect on its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timebase enable, one cycle wide |
| dual_mode | input | 1 | Strap: 1 = both buttons required, 0 = button A only |
| btn_a_n | input | 1 | Raw button A level, low = pressed |
| btn_b_n | input | 1 | Raw button B level, low = pressed |
| rst_req | output | 1 | One-cycle request at the start of each pulse |
| rst_out_n | output | 1 | Stretched reset pulse, active low |

## Verification
Press patterns are timed against a tick index. Each expected pulse must start inside a window measured from the press that should have started its setup, so an early or late start is caught as well as a missing pulse. Short holds, one-button holds in dual mode and button B holds in single mode show whether the hold condition is decoded correctly. A long hold lasting more than twice the setup period shows whether the detector fires once or repeatedly. Brief high excursions, both during setup and after a pulse, separate a correct release filter from one that restarts or re-arms on contact bounce. A release in the middle of a pulse checks that the pulse length does not depend on the buttons.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMING   = 2'd1,
        ST_PULSE    = 2'd2,
        ST_WAIT_REL = 2'd3
    } lrd_state_e;

    typedef struct packed {
        logic b;
        logic a;
    } btn_pair_t;

    localparam int NUM_BTN = 2;

    function automatic logic hold_met(input logic dual, input btn_pair_t held);
        return dual ? (held.a & held.b) : held.a;
    endfunction

endpackage

// File: rtl/lrd_sync.sv
module lrd_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '1;
                end else if (s == 0) begin
                    chain[s] <= d;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lrd_rel_filter.sv
module lrd_rel_filter #(
    parameter int REL_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic lvl_n,
    output logic held
);
    localparam int CW = $clog2(REL_TICKS + 1);
    localparam logic [CW-1:0] REL_C  = CW'(REL_TICKS);
    localparam logic [CW-1:0] REL_M1 = CW'(REL_TICKS - 1);

    logic [CW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= REL_C;
            held   <= 1'b0;
        end else if (!lvl_n) begin
            hi_cnt <= '0;
            held   <= 1'b1;
        end else if (tick && hi_cnt != REL_C) begin
            hi_cnt <= hi_cnt + 1'b1;
            if (hi_cnt == REL_M1) begin
                held <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lrd_fsm.sv
module lrd_fsm
    import lrd_pkg::*;
#(
    parameter int SETUP_TICKS = 6720,
    parameter int PULSE_TICKS = 210,
    localparam int SW = $clog2(SETUP_TICKS),
    localparam int PW = $clog2(PULSE_TICKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          hold,
    output logic          req,
    output logic          pulse_on,
    output lrd_state_e    state_o,
    output logic [SW-1:0] setup_cnt_o
);
    localparam logic [SW-1:0] SETUP_LAST = SW'(SETUP_TICKS - 1);
    localparam logic [PW-1:0] PULSE_LAST = PW'(PULSE_TICKS - 1);

    lrd_state_e    state_q;
    logic [SW-1:0] setup_cnt;
    logic [PW-1:0] pulse_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            setup_cnt <= '0;
            pulse_cnt <= '0;
            req       <= 1'b0;
        end else begin
            req <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    setup_cnt <= '0;
                    if (hold) state_q <= ST_ARMING;
                end
                ST_ARMING: begin
                    if (!hold) begin
                        state_q   <= ST_IDLE;
                        setup_cnt <= '0;
                    end else if (tick) begin
                        if (setup_cnt == SETUP_LAST) begin
                            state_q   <= ST_PULSE;
                            pulse_cnt <= '0;
                            req       <= 1'b1;
                        end else begin
                            setup_cnt <= setup_cnt + 1'b1;
                        end
                    end
                end
                ST_PULSE: begin
                    if (tick) begin
                        if (pulse_cnt == PULSE_LAST) state_q <= ST_WAIT_REL;
                        else pulse_cnt <= pulse_cnt + 1'b1;
                    end
                end
                ST_WAIT_REL: begin
                    if (!hold) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign pulse_on    = (state_q == ST_PULSE);
    assign state_o     = state_q;
    assign setup_cnt_o = setup_cnt;
endmodule

// File: rtl/lrd_top.sv
module lrd_top
    import lrd_pkg::*;
#(
    parameter int SETUP_TICKS = 6720,
    parameter int PULSE_TICKS = 210,
    parameter int REL_TICKS   = 20,
    localparam int SW = $clog2(SETUP_TICKS)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic dual_mode,
    input  logic btn_a_n,
    input  logic btn_b_n,
    output logic rst_req,
    output logic rst_out_n
);
    logic [NUM_BTN-1:0] raw_n, sync_n, held_v;
    btn_pair_t          held;
    logic               hold;
    logic               pulse_on;
    lrd_state_e         state_w;
    logic [SW-1:0]      setup_cnt_w;

    assign raw_n = {btn_b_n, btn_a_n};

    lrd_sync #(.W(NUM_BTN), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_n),
        .q   (sync_n)
    );

    genvar i;
    generate
        for (i = 0; i < NUM_BTN; i++) begin : g_filt
            lrd_rel_filter #(.REL_TICKS(REL_TICKS)) u_filt (
                .clk   (clk),
                .rst   (rst),
                .tick  (tick),
                .lvl_n (sync_n[i]),
                .held  (held_v[i])
            );
        end
    endgenerate

    assign held = held_v;
    assign hold = hold_met(dual_mode, held);

    lrd_fsm #(.SETUP_TICKS(SETUP_TICKS), .PULSE_TICKS(PULSE_TICKS)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .hold        (hold),
        .req         (rst_req),
        .pulse_on    (pulse_on),
        .state_o     (state_w),
        .setup_cnt_o (setup_cnt_w)
    );

    assign rst_out_n = ~pulse_on;
endmodule

// File: rtl/lrd_checker.sv
module lrd_checker
    import lrd_pkg::*;
#(
    parameter int SETUP_TICKS = 6720,
    parameter int PULSE_TICKS = 210,
    parameter int SW = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          hold,
    input logic          rst_req,
    input logic          rst_out_n,
    input lrd_state_e    state,
    input logic [SW-1:0] setup_cnt
);
    int unsigned lo_ticks;

    always_ff @(posedge clk) begin
        if (rst || rst_out_n) lo_ticks <= 0;
        else if (tick) lo_ticks <= lo_ticks + 1;
    end

    // R5: the pulse never counts more ticks than configured
    p_pulse_bound_r5: assert property (@(posedge clk) disable iff (rst)
        lo_ticks <= PULSE_TICKS);

    // R5: when the pulse ends it has lasted the full length
    p_pulse_len_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_out_n) |-> lo_ticks == PULSE_TICKS);

    // R5: request is one cycle wide
    p_req_single_r5: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R5: request marks exactly the falling edge of the pulse
    p_req_edge_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out_n) |-> rst_req);

    p_edge_req_r5: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $fell(rst_out_n));

    // R2: a pulse follows a full setup count
    p_setup_full_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out_n) |-> $past(setup_cnt) == SW'(SETUP_TICKS - 1));

    // R3: losing the hold condition during setup abandons it
    p_hold_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMING && !hold) |=> state == ST_IDLE);

    // R6: after a pulse the detector waits for a release
    p_wait_rel_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_REL && hold) |=> state == ST_WAIT_REL);
endmodule

bind lrd_top lrd_checker #(
    .SETUP_TICKS (SETUP_TICKS),
    .PULSE_TICKS (PULSE_TICKS),
    .SW          (SW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .hold      (hold),
    .rst_req   (rst_req),
    .rst_out_n (rst_out_n),
    .state     (state_w),
    .setup_cnt (setup_cnt_w)
);

// File: tb/tb_lrd_top.sv
module tb_lrd_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int SETUP = 20;
    localparam int PULS  = 5;
    localparam int REL   = 3;

    typedef struct {
        int min_start;
        int max_start;
        int len;
    } exp_t;

    logic clk = 0, rst = 1, tick = 0, dual_mode = 0, btn_a_n = 1, btn_b_n = 1;
    logic rst_req, rst_out_n;
    int   n_chk = 0, n_bad = 0, tick_idx = 0;
    bit   done = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    lrd_top #(.SETUP_TICKS(SETUP), .PULSE_TICKS(PULS), .REL_TICKS(REL)) dut (
        .clk(clk), .rst(rst), .tick(tick), .dual_mode(dual_mode),
        .btn_a_n(btn_a_n), .btn_b_n(btn_b_n),
        .rst_req(rst_req), .rst_out_n(rst_out_n)
    );

    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 tick = 1; tick_idx++;
            @(posedge clk);
            #1 tick = 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            @(posedge tick);
            @(negedge tick);
        end
    endtask

    task automatic expect_pulse(input int from);
        exp_t e;
        e.min_start = from + SETUP;
        e.max_start = from + SETUP + 2;
        e.len       = PULS;
        exp_q.push_back(e);
    endtask

    task automatic settle(input string req);
        btn_a_n = 1; btn_b_n = 1;
        wait_ticks(REL + 4);
        check(exp_q.size() == 0, req, "expected pulses still pending", exp_q.size(), 0);
        check(rst_out_n == 1'b1, req, "rst_out_n after release", rst_out_n, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // monitor: pops expected pulses and compares start and length
    bit prev_low = 0;
    int run_ticks = 0, start_idx = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (!rst_out_n && !prev_low) begin
                check(rst_req == 1'b1, "R5", "rst_req at pulse start", rst_req, 1);
                start_idx = tick_idx;
                run_ticks = 0;
            end else if (rst_req) begin
                check(1'b0, "R5", "rst_req outside pulse start", 1, 0);
            end
            if (!rst_out_n && tick) run_ticks++;
            if (rst_out_n && prev_low) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6", "unexpected pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(start_idx >= e.min_start && start_idx <= e.max_start,
                          "R2", "pulse start tick", start_idx, e.min_start);
                    check(run_ticks == e.len, "R5", "pulse length in ticks", run_ticks, e.len);
                end
            end
            prev_low = !rst_out_n;
        end
    end

    initial begin
        #(5.0 * 150000);
        check(1'b0, "WDOG", "watchdog expired", 1, 0);
        finish_run();
    end

    initial begin
        int p;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(rst_out_n == 1'b1, "R1", "rst_out_n in reset", rst_out_n, 1);
        check(rst_req == 1'b0, "R1", "rst_req in reset", rst_req, 0);
        @(posedge clk); #1 rst = 0;
        wait_ticks(2);
        check(rst_out_n == 1'b1 && rst_req == 1'b0, "R1", "idle after reset", rst_out_n, 1);

        // R2: two short holds, each below the setup period
        dual_mode = 0;
        btn_a_n = 0; wait_ticks(SETUP - 4);
        btn_a_n = 1; wait_ticks(REL + 2);
        btn_a_n = 0; wait_ticks(SETUP - 4);
        settle("R2");

        // R2 R6: one long hold gives exactly one pulse
        p = tick_idx; btn_a_n = 0; expect_pulse(p);
        wait_ticks(2 * SETUP + PULS + 5);
        settle("R6");

        // R6: release and hold again re-arms
        p = tick_idx; btn_a_n = 0; expect_pulse(p);
        wait_ticks(SETUP + PULS + 4);
        settle("R6");

        // R4: button B alone in single mode
        btn_b_n = 0; wait_ticks(SETUP + 6);
        settle("R4");

        // R3: one button alone in dual mode
        dual_mode = 1;
        btn_a_n = 0; wait_ticks(SETUP + 6);
        settle("R3");
        btn_b_n = 0; wait_ticks(SETUP + 6);
        settle("R3");

        // R3: both buttons held
        p = tick_idx; btn_a_n = 0; btn_b_n = 0; expect_pulse(p);
        wait_ticks(SETUP + PULS + 4);
        settle("R3");

        // R3: releasing B during setup restarts the count
        btn_a_n = 0; btn_b_n = 0; wait_ticks(8);
        btn_b_n = 1; wait_ticks(REL + 2);
        p = tick_idx; btn_b_n = 0; expect_pulse(p);
        wait_ticks(SETUP + PULS + 4);
        settle("R3");

        // R7: short bounce during setup does not restart
        dual_mode = 0;
        p = tick_idx; btn_a_n = 0; expect_pulse(p);
        wait_ticks(8);
        btn_a_n = 1; wait_ticks(1);
        btn_a_n = 0; wait_ticks(SETUP + PULS);
        settle("R7");

        // R7 R6: short bounce after a pulse does not re-arm
        p = tick_idx; btn_a_n = 0; expect_pulse(p);
        wait_ticks(SETUP + PULS + 4);
        btn_a_n = 1; wait_ticks(1);
        btn_a_n = 0; wait_ticks(SETUP + 4);
        settle("R7");

        // R8: release during the pulse leaves its length unchanged
        p = tick_idx; btn_a_n = 0; expect_pulse(p);
        wait (rst_out_n == 1'b0);
        #1 btn_a_n = 1;
        wait_ticks(1);
        btn_a_n = 0; wait_ticks(1);
        btn_a_n = 1;
        wait_ticks(PULS + 2);
        settle("R8");

        finish_run();
    end
endmodule